// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between one core's load/store port and a shared memory port. Stores from the core go into a small in-order queue and are written to memory one at a time. Each store leaves the queue only when memory acknowledges it. A load whose address matches nothing in the queue may go to memory ahead of the older queued stores. This hides store latency from the core.

A static mode input sets how a load to a queued address is handled. In strict mode the load waits until every matching store has been acknowledged, then reads memory. In forwarding mode the load returns the value of the youngest matching queued store on the next cycle and never reaches memory. A read-modify-write request (a swap: memory returns the old word and stores the new one) waits until the queue is fully drained. It then goes to memory, so it acts as an ordering point. The core issues one request per cycle. Any load or swap that is in flight holds off further requests until its response arrives.

Top module: `store_buffer_fwd`

## Requirements
- R1: After reset the queue is empty, `req_ready` is high, and `mem_req_valid` and `rsp_valid` are low.
- R2: Request codes: 0 = load, 1 = store, 2 = swap (3 behaves as a load). A store is accepted only while fewer than DEPTH stores are queued. With DEPTH stores queued, `req_ready` is low for a store request.
- R3: Stores reach memory in the order they were accepted. At most one memory transaction is outstanding. `mem_req_valid` and its op, address and data stay stable until the cycle `mem_ack` is high, and a store leaves the queue in that cycle.
- R4: A load whose address matches no queued store is sent to memory ahead of older queued stores that have not been issued. `rsp_valid` rises in the cycle after `mem_ack` and carries the memory data.
- R5: In strict mode (`fwd_mode`=0), a load whose address matches a queued store is not sent to memory until no matching store remains queued. It then returns the memory value.
- R6: In forwarding mode (`fwd_mode`=1), a load that matches a queued store gets `rsp_valid` one cycle after acceptance with the store's data. It issues no memory request.
- R7: A swap is sent to memory only when the queue is empty and no transaction is outstanding. Its response carries the old memory value, and memory then holds the new word.
- R8: While a load or swap is pending, `req_ready` is low for every request.
- R9: When several queued stores match a forwarded load, the data comes from the most recently accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_mode | input | 1 | 0 = strict, 1 = forward from queued stores; static |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_op | input | 2 | 0 load, 1 store, 2 swap |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store or swap data |
| rsp_valid | output | 1 | One-cycle pulse with load or swap result |
| rsp_rdata | output | DW | Result data |
| mem_req_valid | output | 1 | Memory transaction request, held until ack |
| mem_req_op | output | 2 | Same encoding as req_op |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the outstanding transaction |
| mem_rdata | input | DW | Read data, valid with mem_ack |

## Verification
The embedded properties check several rules on every cycle:
- The memory request stays stable until acknowledged.
- A store is issued only from the queue head.
- A swap goes out only on an empty queue.
- A load reaches memory only with no matching queued store.
- The queue neither overflows nor underflows.
- The one-cycle forwarding response arrives when required.

Only the bench scenarios can show the rest. These are the global store order seen by memory, that a non-matching load really overtakes older stores, and that data comes from the youngest of several matches. Another is the back-pressure when the queue is full or a load is pending. The last is the end-to-end value each load and swap returns in both modes.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_RMW   = 2'd2
  } sbf_op_e;
endpackage

// File: rtl/sbf_queue.sv
// In-order store queue: push at tail, pop at head, per-slot valid bits exposed
// for the address matcher.
module sbf_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DEPTH-1:0][AW-1:0]   ent_addr,
  output logic [DEPTH-1:0][DW-1:0]   ent_data,
  output logic [DEPTH-1:0]           ent_valid,
  output logic [PW-1:0]              head_ptr,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic                       empty,
  output logic                       full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]             head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]             cnt_q, cnt_d;
  logic [DEPTH-1:0]          vld_q, vld_d;
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    vld_d  = vld_q;
    if (pop) begin
      vld_d[head_q] = 1'b0;
      head_d        = head_q + 1'b1;
    end
    if (push) begin
      vld_d[tail_q] = 1'b1;
      tail_d        = tail_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
    end
  end

  // Payload storage needs no reset: slots are qualified by vld_q.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  assign ent_addr  = addr_q;
  assign ent_data  = data_q;
  assign ent_valid = vld_q;
  assign head_ptr  = head_q;
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sbf_match.sv
// Address comparator over all queue slots; walks slots oldest to youngest so
// the last hit (the youngest) supplies the data.
module sbf_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [DEPTH-1:0]         ent_valid,
  input  logic [PW-1:0]            head_ptr,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  logic [DEPTH-1:0] eq;
  logic [PW-1:0]    slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_addr[g] == look_addr);
  end

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    slot     = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_ptr + PW'(k);
      if (eq[slot]) begin
        hit      = 1'b1;
        hit_data = ent_data[slot];
      end
    end
  end
endmodule

// File: rtl/sbf_memport.sv
// Single-outstanding memory port: chooses between the pending load/swap and
// the queue head, holds the request until acknowledged.
module sbf_memport
  import sbf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_valid,
  input  sbf_op_e       pend_op,
  input  logic [AW-1:0] pend_addr,
  input  logic [DW-1:0] pend_wdata,
  input  logic          pend_hit,
  input  logic          buf_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          mem_req_valid,
  output logic [1:0]    mem_req_op,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          pop,
  output logic          pend_done,
  output logic [DW-1:0] pend_rdata
);
  logic          out_valid_q, out_valid_d;
  sbf_op_e       out_op_q, out_op_d;
  logic [AW-1:0] out_addr_q, out_addr_d;
  logic [DW-1:0] out_wdata_q, out_wdata_d;
  logic          issue_pend, issue_drain, done;

  always_comb begin
    done        = out_valid_q && mem_ack;
    issue_pend  = !out_valid_q && pend_valid &&
                  (((pend_op == OP_RMW) && buf_empty) ||
                   ((pend_op != OP_RMW) && !pend_hit));
    issue_drain = !out_valid_q && !issue_pend && !buf_empty;

    out_valid_d = out_valid_q;
    out_op_d    = out_op_q;
    out_addr_d  = out_addr_q;
    out_wdata_d = out_wdata_q;
    if (done) begin
      out_valid_d = 1'b0;
    end
    if (issue_pend) begin
      out_valid_d = 1'b1;
      out_op_d    = (pend_op == OP_RMW) ? OP_RMW : OP_LOAD;
      out_addr_d  = pend_addr;
      out_wdata_d = pend_wdata;
    end else if (issue_drain) begin
      out_valid_d = 1'b1;
      out_op_d    = OP_STORE;
      out_addr_d  = head_addr;
      out_wdata_d = head_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_op_q    <= OP_LOAD;
      out_addr_q  <= '0;
      out_wdata_q <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_op_q    <= out_op_d;
      out_addr_q  <= out_addr_d;
      out_wdata_q <= out_wdata_d;
    end
  end

  assign mem_req_valid = out_valid_q;
  assign mem_req_op    = out_op_q;
  assign mem_req_addr  = out_addr_q;
  assign mem_req_wdata = out_wdata_q;
  assign pop           = done && (out_op_q == OP_STORE);
  assign pend_done     = done && (out_op_q != OP_STORE);
  assign pend_rdata    = mem_rdata;

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_op) &&
      $stable(mem_req_addr) && $stable(mem_req_wdata)));
  a_r3_store_from_head: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == 2'd1) |-> (!buf_empty && mem_req_addr == head_addr));
  a_r7_rmw_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == 2'd2) |-> buf_empty);
  a_r5_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == 2'd0) |-> !pend_hit);
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd
  import sbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  output logic [1:0]    mem_req_op,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(DEPTH);

  logic                      pend_valid_q, pend_valid_d;
  sbf_op_e                   pend_op_q, pend_op_d;
  logic [AW-1:0]             pend_addr_q, pend_addr_d;
  logic [DW-1:0]             pend_wdata_q, pend_wdata_d;
  logic                      rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]             rsp_rdata_q, rsp_rdata_d;

  logic                      is_store, is_rmw, is_load, accept;
  logic                      push, pop, fwd_take, to_pend;
  logic                      empty, full, hit, pend_done;
  logic [DW-1:0]             hit_data, pend_rdata;
  logic [AW-1:0]             look_addr, head_addr;
  logic [DW-1:0]             head_data;
  logic [PW-1:0]             head_ptr;
  logic [DEPTH-1:0][AW-1:0]  ent_addr;
  logic [DEPTH-1:0][DW-1:0]  ent_data;
  logic [DEPTH-1:0]          ent_valid;

  assign is_store  = (req_op == OP_STORE);
  assign is_rmw    = (req_op == OP_RMW);
  assign is_load   = !is_store && !is_rmw;
  assign req_ready = !pend_valid_q && !(is_store && full);
  assign accept    = req_valid && req_ready;
  assign look_addr = pend_valid_q ? pend_addr_q : req_addr;
  assign push      = accept && is_store;
  assign fwd_take  = accept && is_load && fwd_mode && hit;
  assign to_pend   = accept && !is_store && !fwd_take;

  always_comb begin
    pend_valid_d = pend_valid_q;
    pend_op_d    = pend_op_q;
    pend_addr_d  = pend_addr_q;
    pend_wdata_d = pend_wdata_q;
    if (to_pend) begin
      pend_valid_d = 1'b1;
      pend_op_d    = is_rmw ? OP_RMW : OP_LOAD;
      pend_addr_d  = req_addr;
      pend_wdata_d = req_wdata;
    end else if (pend_done) begin
      pend_valid_d = 1'b0;
    end
    rsp_valid_d = fwd_take || pend_done;
    rsp_rdata_d = rsp_rdata_q;
    if (fwd_take) begin
      rsp_rdata_d = hit_data;
    end else if (pend_done) begin
      rsp_rdata_d = pend_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_op_q    <= OP_LOAD;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_rdata_q  <= '0;
    end else begin
      pend_valid_q <= pend_valid_d;
      pend_op_q    <= pend_op_d;
      pend_addr_q  <= pend_addr_d;
      pend_wdata_q <= pend_wdata_d;
      rsp_valid_q  <= rsp_valid_d;
      rsp_rdata_q  <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  sbf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) i_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (pop),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .head_ptr  (head_ptr),
    .head_addr (head_addr),
    .head_data (head_data),
    .empty     (empty),
    .full      (full)
  );

  sbf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) i_match (
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .head_ptr  (head_ptr),
    .look_addr (look_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  sbf_memport #(.AW(AW), .DW(DW)) i_memport (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend_valid    (pend_valid_q),
    .pend_op       (pend_op_q),
    .pend_addr     (pend_addr_q),
    .pend_wdata    (pend_wdata_q),
    .pend_hit      (hit),
    .buf_empty     (empty),
    .head_addr     (head_addr),
    .head_data     (head_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_op    (mem_req_op),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .pop           (pop),
    .pend_done     (pend_done),
    .pend_rdata    (pend_rdata)
  );

  a_r6_fwd_next: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode && req_valid && req_ready && req_op == 2'd0 && hit)
      |=> (rsp_valid && rsp_rdata == $past(hit_data)));
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op != 2'd1) |-> !req_ready);
endmodule

// File: tb/test_store_buffer_fwd.sv
`timescale 1ns/1ps
module test_store_buffer_fwd;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fwd_mode;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req_valid;
  logic [1:0]    mem_req_op;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  always #2.5 clk = ~clk;

  store_buffer_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_buffer_fwd (
    .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_op(mem_req_op),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] memv   [256];
  int            pcnt   [256];
  int            ptot;
  int            lat;
  int            wcnt;
  int            n_memload;
  bit            saw_bypass;
  logic [AW-1:0] st_a_q [$];
  logic [DW-1:0] st_d_q [$];
  logic [DW-1:0] exp_q  [$];
  string         tag_q  [$];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model: acks after lat idle cycles, checks ordering rules
  task automatic serve();
    int a;
    a = int'(mem_req_addr[7:0]);
    case (mem_req_op)
      2'd1: begin
        if (st_a_q.size() == 0) begin
          chk(0, "R3 unexpected store", mem_req_addr, 0);
        end else begin
          logic [AW-1:0] ea;
          logic [DW-1:0] ed;
          ea = st_a_q.pop_front();
          ed = st_d_q.pop_front();
          chk(mem_req_addr == ea && mem_req_wdata == ed, "R3 store order",
              {mem_req_addr, mem_req_wdata}, {ea, ed});
        end
        memv[a] = mem_req_wdata;
        pcnt[a]--;
        ptot--;
      end
      2'd2: begin
        chk(ptot == 0, "R7 swap before drain", ptot, 0);
        mem_rdata = memv[a];
        memv[a]   = mem_req_wdata;
      end
      default: begin
        n_memload++;
        chk(pcnt[a] == 0, "R5 load passed matching store", pcnt[a], 0);
        if (ptot > 0) saw_bypass = 1'b1;
        mem_rdata = memv[a];
      end
    endcase
  endtask

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    wcnt      = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt    = 0;
      end else if (rst_n && mem_req_valid) begin
        if (wcnt >= lat) begin
          serve();
          mem_ack = 1'b1;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  // monitor: pop scoreboard on each response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected response", rsp_rdata, 0);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_rdata == e, t, rsp_rdata, e);
        end
      end
    end
  end

  // driver
  task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    int ix;
    ix = int'(a[7:0]);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    case (op)
      2'd1: begin
        shadow[ix] = d;
        st_a_q.push_back(a);
        st_d_q.push_back(d);
        pcnt[ix]++;
        ptot++;
      end
      2'd2: begin
        exp_q.push_back(shadow[ix]);
        tag_q.push_back(tag);
        shadow[ix] = d;
      end
      default: begin
        exp_q.push_back(shadow[ix]);
        tag_q.push_back(tag);
      end
    endcase
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || ptot != 0 || mem_req_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    fwd_mode  = mode;
    ptot      = 0;
    for (int i = 0; i < 256; i++) pcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    req_op = 2'd0; req_addr = '0; req_wdata = '0;
    saw_bypass = 1'b0; n_memload = 0; lat = 2;
    for (int i = 0; i < 256; i++) begin
      shadow[i] = 32'hC0DE_0000 + i;
      memv[i]   = 32'hC0DE_0000 + i;
    end

    // R1: reset state
    do_reset(1'b0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 no mem request", mem_req_valid, 0);
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);

    // R3/R5: strict mode, same-address stores then load
    send(2'd1, 16'h10, 32'hA1, "");
    send(2'd1, 16'h11, 32'hA2, "");
    send(2'd1, 16'h10, 32'hA3, "");
    send(2'd0, 16'h10, 0, "R5 strict load value");
    wait_idle();
    chk(memv[16'h10] == 32'hA3, "R3 final memory word", memv[16'h10], 32'hA3);

    // R4: non-matching load bypasses older stores
    lat = 6;
    saw_bypass = 1'b0;
    send(2'd1, 16'h20, 32'hB0, "");
    send(2'd1, 16'h21, 32'hB1, "");
    send(2'd1, 16'h22, 32'hB2, "");
    send(2'd0, 16'h30, 0, "R4 bypass load value");
    wait_idle();
    chk(saw_bypass, "R4 load overtook stores", saw_bypass, 1);

    // R5/R8: strict matching load stalls; requests blocked meanwhile
    lat = 4;
    send(2'd1, 16'h40, 32'h55, "");
    send(2'd0, 16'h40, 0, "R5 stalled load value");
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h41; req_wdata = 32'h66;
    #0.1;
    chk(req_ready == 1'b0, "R8 ready low while load pending", req_ready, 0);
    req_valid = 1'b0;
    wait_idle();

    // R7: swap drains queue first and returns old value
    lat = 3;
    send(2'd1, 16'h50, 32'h1, "");
    send(2'd1, 16'h51, 32'h2, "");
    send(2'd2, 16'h50, 32'h9, "R7 swap old value");
    send(2'd0, 16'h50, 0, "R7 load after swap");
    wait_idle();
    chk(memv[16'h50] == 32'h9, "R7 swap wrote memory", memv[16'h50], 32'h9);

    // R2: full queue back-pressures stores
    lat = 40;
    for (int i = 0; i < DEPTH; i++) send(2'd1, 16'h60 + 16'(i), 32'h600 + i, "");
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h70; req_wdata = 32'h77;
    #0.1;
    chk(req_ready == 1'b0, "R2 ready low when full", req_ready, 0);
    req_valid = 1'b0;
    send(2'd1, 16'h70, 32'h77, "");
    lat = 1;
    wait_idle();
    chk(memv[16'h70] == 32'h77, "R2 blocked store later written", memv[16'h70], 32'h77);

    // R6/R9: forwarding mode
    do_reset(1'b1);
    lat = 20;
    send(2'd1, 16'h80, 32'h11, "");
    send(2'd1, 16'h80, 32'h22, "");
    send(2'd1, 16'h81, 32'h33, "");
    begin
      int m0;
      m0 = n_memload;
      send(2'd0, 16'h80, 0, "R9 youngest match data");
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R6 forward after one cycle", rsp_valid, 1);
      send(2'd0, 16'h81, 0, "R6 forwarded data");
      chk(n_memload == m0, "R6 no memory load on forward", n_memload, m0);
    end
    send(2'd0, 16'h82, 0, "R4 unmatched load in forward mode");
    wait_idle();

    // R7 in forwarding mode
    lat = 2;
    send(2'd1, 16'h90, 32'h5, "");
    send(2'd2, 16'h90, 32'h6, "R7 swap old value fwd mode");
    send(2'd0, 16'h90, 0, "R7 load after swap fwd mode");
    wait_idle();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule